// File: doc/BRIEF.md
# SD Host Single-Address DMA Engine

This block moves data blocks between the card-side data FIFOs of an SD host controller and system memory. Software loads a start address, a block length with a boundary code, a block count and a transfer mode through a small register port. Writing the mode register with the DMA-enable bit set starts the transfer. From then on the engine issues one memory word request per granted cycle, advancing the address by one word each time.

When the address reaches a power-of-two memory boundary, the engine parks itself and flags a DMA interrupt status bit. Software then rewrites the system address register, normally with the value it reads back, and the transfer continues from where it stopped. After the last word of the last block the engine flags transfer complete and returns to idle. Both status flags are write-one-to-clear.

Register selects on `reg_sel_i`:

| Select | Register |
|--------|----------|
| 0 | system address |
| 1 | block size |
| 2 | block count |
| 3 | transfer mode |
| 4 | status |
| 5 | host control |

Reading any other select returns 0.

Top module: `sdma_engine`

## Requirements
- R1: After reset every register reads 0, the engine is idle and `mem_req_o` is low.
- R2: A transfer starts only on a write to the transfer mode register (select 3) made while idle, and only when all of these hold:
  - written bit 0 (DMA enable) is 1;
  - host control bits [4:3] (DMA select) are 00;
  - the block length gives at least one word, that is block size bits [11:2] are nonzero;
  - it is not the case that written bit 5 (multi-block) and bit 1 (count enable) are both set while the block count is 0.

  Otherwise the mode value is stored but no request is made.
- R3: Each granted beat (`mem_req_o && mem_gnt_i`) increments the address by 4. Select 0 reads back the address of the next access.
- R4: Mode bit 4 sets the direction.
  - Bit 4 = 1 (read from card): a request is made only while `rx_valid_i` is high, with `mem_we_o`=1 and `mem_wdata_o`=`rx_data_i`; `rx_ready_o` pulses on each beat.
  - Bit 4 = 0 (write to card): a request is made only while `tx_ready_i` is high, with `mem_we_o`=0; `tx_valid_o` pulses on each beat with `tx_data_o`=`mem_rdata_i`.
  - No request is made outside a running transfer.
- R5: Block size bits [14:12] hold a code c, and the boundary is 2^(BND_BASE_LOG2+c) bytes. When the address after a beat is a multiple of the boundary and the transfer is not finished, the engine pauses: it makes no requests and sets status bit 3.
- R6: A write to select 0 while paused loads the address and resumes the transfer with the remaining words and blocks.
- R7: With mode bit 1 set, the block count decrements after each completed block. The last block is:
  - the first block when mode bit 5 is clear;
  - the block that takes the count from 1 to 0 when bits 5 and 1 are both set.

  With bit 5 set and bit 1 clear, blocks continue without end.
- R8: Finishing the last block sets status bit 1 and returns to idle. If the final beat also lands on a boundary, bit 3 is not set.
- R9: A write to select 4 clears each status bit written as 1 and leaves bits written as 0 unchanged.
- R10: While a transfer is running or paused, writes to selects 1, 2, 3 and 5 are ignored. While running, writes to select 0 are also ignored.
- R11: Read-back widths:
  - select 1 returns bits [14:0];
  - select 2 returns bits [15:0];
  - select 3 returns bits 0, 1, 2, 4 and 5 of the stored mode;
  - select 5 returns bits [7:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| reg_we_i | input | 1 | register write strobe |
| reg_sel_i | input | 3 | register select |
| reg_wdata_i | input | REG_W | register write data |
| reg_rdata_o | output | REG_W | register read data for `reg_sel_i` |
| mem_req_o | output | 1 | memory access request |
| mem_we_o | output | 1 | memory access is a write |
| mem_addr_o | output | ADDR_W | memory byte address |
| mem_wdata_o | output | DATA_W | memory write data |
| mem_gnt_i | input | 1 | memory accepts the request this cycle |
| mem_rdata_i | input | DATA_W | memory read data, valid with grant |
| rx_valid_i | input | 1 | card receive FIFO has a word |
| rx_data_i | input | DATA_W | card receive FIFO word |
| rx_ready_o | output | 1 | receive FIFO word consumed |
| tx_valid_o | output | 1 | word pushed to card transmit FIFO |
| tx_data_o | output | DATA_W | card transmit FIFO word |
| tx_ready_i | input | 1 | card transmit FIFO has room |

## Verification
The bench builds the engine with BND_BASE_LOG2=6, so boundary code 0 is a 64-byte boundary and code 7 is an 8 KiB boundary. With that setting a pause comes after 16 words instead of 1024. Within a few dozen cycles the bench can reach a pause in the middle of a multi-block transfer, a final beat that lands exactly on a boundary, and an endless multi-block run that stops at every boundary. Grant and FIFO readiness follow a pseudo-random pattern, so stalls fall at different points within blocks.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RUN = 2'd1, ST_PAUSE = 2'd2} sdma_state_e;

  localparam logic [2:0] SEL_SADDR = 3'd0;
  localparam logic [2:0] SEL_BSIZE = 3'd1;
  localparam logic [2:0] SEL_BCNT  = 3'd2;
  localparam logic [2:0] SEL_MODE  = 3'd3;
  localparam logic [2:0] SEL_STAT  = 3'd4;
  localparam logic [2:0] SEL_HCTL  = 3'd5;

  localparam int MODE_DMA_EN = 0;
  localparam int MODE_CNT_EN = 1;
  localparam int MODE_DIR_RD = 4;
  localparam int MODE_MULTI  = 5;
  localparam logic [5:0] MODE_MASK = 6'b11_0111;

  localparam int STAT_TC  = 1;
  localparam int STAT_DMA = 3;
endpackage

// File: rtl/sdma_bnd_det.sv
module sdma_bnd_det #(
  parameter int ADDR_W        = 32,
  parameter int BND_BASE_LOG2 = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        code_i,
  output logic              at_edge_o
);
  logic [7:0] edge_vec;

  for (genvar c = 0; c < 8; c++) begin : g_code
    assign edge_vec[c] = ~|addr_i[BND_BASE_LOG2+c-1:0];
  end

  assign at_edge_o = edge_vec[code_i];
endmodule

// File: rtl/sdma_blk_tracker.sv
module sdma_blk_tracker #(
  parameter int CNT_W = 16,
  parameter int WPB_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             start_i,
  input  logic             beat_i,
  input  logic [WPB_W-1:0] wpb_i,
  input  logic             cnt_en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             blk_end_o
);
  logic [WPB_W-1:0] wcnt_q;
  logic [CNT_W-1:0] cnt_q;

  assign blk_end_o = beat_i && (wcnt_q == wpb_i - 1'b1);
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q <= '0;
    end else if (start_i) begin
      wcnt_q <= '0;
    end else if (beat_i) begin
      wcnt_q <= blk_end_o ? '0 : wcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_wr_i) begin
      cnt_q <= cnt_wdata_i;
    end else if (blk_end_o && cnt_en_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assert_cnt_dec_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_end_o && cnt_en_i && cnt_q != '0 && !cnt_wr_i) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/sdma_ctrl.sv
module sdma_ctrl import sdma_pkg::*; (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        resume_i,
  input  logic        xfer_end_i,
  input  logic        bnd_hit_i,
  input  logic        clr_tc_i,
  input  logic        clr_dma_i,
  output sdma_state_e state_o,
  output logic        tc_o,
  output logic        dma_o
);
  sdma_state_e state_q, state_d;
  logic set_tc, set_dma, tc_q, dma_q;

  always_comb begin
    state_d = state_q;
    set_tc  = 1'b0;
    set_dma = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_RUN;
      ST_RUN: begin
        if (xfer_end_i) begin
          state_d = ST_IDLE;
          set_tc  = 1'b1;
        end else if (bnd_hit_i) begin
          state_d = ST_PAUSE;
          set_dma = 1'b1;
        end
      end
      ST_PAUSE: if (resume_i) state_d = ST_RUN;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tc_q    <= 1'b0;
      dma_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      // set wins over a same-cycle clear
      if (set_tc) tc_q <= 1'b1;
      else if (clr_tc_i) tc_q <= 1'b0;
      if (set_dma) dma_q <= 1'b1;
      else if (clr_dma_i) dma_q <= 1'b0;
    end
  end

  assign state_o = state_q;
  assign tc_o    = tc_q;
  assign dma_o   = dma_q;

  assert_pause_flags_dma_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PAUSE && $past(state_q) == ST_RUN) |-> dma_q);
  assert_done_flags_tc_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && $past(state_q) == ST_RUN) |-> tc_q);
  assert_w1c_tc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_tc_i && !xfer_end_i) |=> !tc_q);
  assert_w1c_dma_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_dma_i && !bnd_hit_i) |=> !dma_q);
endmodule

// File: rtl/sdma_engine.sv
module sdma_engine import sdma_pkg::*; #(
  parameter int REG_W         = 32,
  parameter int ADDR_W        = 32,
  parameter int DATA_W        = 32,
  parameter int CNT_W         = 16,
  parameter int BLKLEN_W      = 12,
  parameter int BND_BASE_LOG2 = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_sel_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_gnt_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              rx_ready_o,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_data_o,
  input  logic              tx_ready_i
);
  localparam int BYTES     = DATA_W / 8;
  localparam int BYTE_LOG2 = $clog2(BYTES);
  localparam int WPB_W     = BLKLEN_W - BYTE_LOG2;
  localparam int BSZ_W     = BLKLEN_W + 3;

  sdma_state_e state;
  logic [ADDR_W-1:0] sysaddr_q, addr_nxt;
  logic [BSZ_W-1:0]  bsize_q;
  logic [5:0]        mode_q;
  logic [7:0]        hctl_q;
  logic [CNT_W-1:0]  cnt;
  logic [WPB_W-1:0]  wpb;
  logic idle, running, paused, dir_rd;
  logic wr_saddr, wr_bsize, wr_bcnt, wr_mode, wr_stat, wr_hctl;
  logic start, resume, beat, blk_end, last_blk, xfer_end, at_edge, bnd_hit;
  logic tc, dma;

  assign idle    = (state == ST_IDLE);
  assign running = (state == ST_RUN);
  assign paused  = (state == ST_PAUSE);

  assign wr_saddr = reg_we_i && reg_sel_i == SEL_SADDR;
  assign wr_bsize = reg_we_i && reg_sel_i == SEL_BSIZE;
  assign wr_bcnt  = reg_we_i && reg_sel_i == SEL_BCNT;
  assign wr_mode  = reg_we_i && reg_sel_i == SEL_MODE;
  assign wr_stat  = reg_we_i && reg_sel_i == SEL_STAT;
  assign wr_hctl  = reg_we_i && reg_sel_i == SEL_HCTL;

  assign wpb    = bsize_q[BLKLEN_W-1:BYTE_LOG2];
  assign dir_rd = mode_q[MODE_DIR_RD];

  assign start = wr_mode && idle && reg_wdata_i[MODE_DMA_EN] && hctl_q[4:3] == 2'b00
              && wpb != '0
              && !(reg_wdata_i[MODE_MULTI] && reg_wdata_i[MODE_CNT_EN] && cnt == '0);
  assign resume = wr_saddr && paused;

  // memory and FIFO side
  assign mem_req_o   = running && (dir_rd ? rx_valid_i : tx_ready_i);
  assign mem_we_o    = running && dir_rd;
  assign mem_addr_o  = sysaddr_q;
  assign mem_wdata_o = rx_data_i;
  assign beat        = mem_req_o && mem_gnt_i;
  assign rx_ready_o  = beat && dir_rd;
  assign tx_valid_o  = beat && !dir_rd;
  assign tx_data_o   = mem_rdata_i;

  assign addr_nxt = sysaddr_q + ADDR_W'(BYTES);
  assign last_blk = !mode_q[MODE_MULTI] || (mode_q[MODE_CNT_EN] && cnt == CNT_W'(1));
  assign xfer_end = blk_end && last_blk;
  assign bnd_hit  = beat && at_edge;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sysaddr_q <= '0;
    end else if (wr_saddr && !running) begin
      sysaddr_q <= reg_wdata_i[ADDR_W-1:0];
    end else if (beat) begin
      sysaddr_q <= addr_nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bsize_q <= '0;
      mode_q  <= '0;
      hctl_q  <= '0;
    end else if (idle) begin
      if (wr_bsize) bsize_q <= reg_wdata_i[BSZ_W-1:0];
      if (wr_mode)  mode_q  <= reg_wdata_i[5:0] & MODE_MASK;
      if (wr_hctl)  hctl_q  <= reg_wdata_i[7:0];
    end
  end

  sdma_bnd_det #(.ADDR_W(ADDR_W), .BND_BASE_LOG2(BND_BASE_LOG2)) u_bnd (
    .addr_i   (addr_nxt),
    .code_i   (bsize_q[BSZ_W-1:BLKLEN_W]),
    .at_edge_o(at_edge)
  );

  sdma_blk_tracker #(.CNT_W(CNT_W), .WPB_W(WPB_W)) u_trk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_wr_i   (wr_bcnt && idle),
    .cnt_wdata_i(reg_wdata_i[CNT_W-1:0]),
    .start_i    (start),
    .beat_i     (beat),
    .wpb_i      (wpb),
    .cnt_en_i   (mode_q[MODE_CNT_EN]),
    .cnt_o      (cnt),
    .blk_end_o  (blk_end)
  );

  sdma_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .resume_i  (resume),
    .xfer_end_i(xfer_end),
    .bnd_hit_i (bnd_hit),
    .clr_tc_i  (wr_stat && reg_wdata_i[STAT_TC]),
    .clr_dma_i (wr_stat && reg_wdata_i[STAT_DMA]),
    .state_o   (state),
    .tc_o      (tc),
    .dma_o     (dma)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_sel_i)
      SEL_SADDR: reg_rdata_o = REG_W'(sysaddr_q);
      SEL_BSIZE: reg_rdata_o = REG_W'(bsize_q);
      SEL_BCNT:  reg_rdata_o = REG_W'(cnt);
      SEL_MODE:  reg_rdata_o = REG_W'(mode_q);
      SEL_STAT: begin
        reg_rdata_o[STAT_TC]  = tc;
        reg_rdata_o[STAT_DMA] = dma;
      end
      SEL_HCTL:  reg_rdata_o = REG_W'(hctl_q);
      default:   reg_rdata_o = '0;
    endcase
  end

  assert_no_req_unless_run_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running |-> !mem_req_o);
  assert_addr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat |=> sysaddr_q == $past(sysaddr_q) + ADDR_W'(BYTES));
  assert_pause_holds_addr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (paused && !wr_saddr) |=> $stable(sysaddr_q));
  assert_busy_bsize_locked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle && wr_bsize) |=> $stable(bsize_q));
endmodule

// File: tb/sdma_engine_tb_top.sv
module sdma_engine_tb_top;
  localparam int BASE = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0;
  logic [2:0] sel = 3'd0;
  logic [31:0] wdata = '0, rdata;
  logic req, mwe, gnt = 1'b0, rxv = 1'b0, rxr, txv, txr = 1'b0;
  logic [31:0] maddr, mwd, mrd = '0, rxd = '0, txd;

  sdma_engine #(.BND_BASE_LOG2(BASE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_sel_i(sel), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .mem_req_o(req), .mem_we_o(mwe), .mem_addr_o(maddr),
    .mem_wdata_o(mwd), .mem_gnt_i(gnt), .mem_rdata_i(mrd), .rx_valid_i(rxv),
    .rx_data_i(rxd), .rx_ready_o(rxr), .tx_valid_o(txv), .tx_data_o(txd), .tx_ready_i(txr)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_state = 0, m_w = 0;
  logic [31:0] m_addr = '0;
  logic [14:0] m_bsz = '0;
  logic [15:0] m_cnt = '0;
  logic [5:0] m_mode = '0;
  logic [7:0] m_hctl = '0;
  bit m_tc = 0, m_dma = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [31:0] m_read(input logic [2:0] s);
    case (s)
      3'd0: return m_addr;
      3'd1: return {17'd0, m_bsz};
      3'd2: return {16'd0, m_cnt};
      3'd3: return {26'd0, m_mode};
      3'd4: return {28'd0, m_dma, 1'b0, m_tc, 1'b0};
      3'd5: return {24'd0, m_hctl};
      default: return 32'd0;
    endcase
  endfunction

  always begin
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    gnt = lfsr[0] | lfsr[3];
    rxv = lfsr[5] | lfsr[7];
    txr = lfsr[6] | lfsr[9];
    rxd = {lfsr, ~lfsr};
    mrd = {~lfsr, lfsr};
    #5;
    if (!rst_n) begin
      m_state = 0; m_w = 0; m_addr = '0; m_bsz = '0; m_cnt = '0;
      m_mode = '0; m_hctl = '0; m_tc = 0; m_dma = 0;
    end else begin
      bit dir, e_req, beat, set_tc, set_dma;
      int old;
      int wpb;
      dir = m_mode[4];
      e_req = (m_state == 1) && (dir ? rxv : txr);
      chk(req == e_req, "R4 mem_req", {31'd0, req}, {31'd0, e_req});
      if (e_req) begin
        chk(maddr == m_addr, "R3 mem_addr", maddr, m_addr);
        chk(mwe == dir, "R4 mem_we", {31'd0, mwe}, {31'd0, dir});
        if (dir) chk(mwd == rxd, "R4 mem_wdata", mwd, rxd);
      end
      chk(rxr == (e_req && gnt && dir), "R4 rx_ready", {31'd0, rxr}, {31'd0, e_req && gnt && dir});
      chk(txv == (e_req && gnt && !dir), "R4 tx_valid", {31'd0, txv}, {31'd0, e_req && gnt && !dir});
      if (txv) chk(txd == mrd, "R4 tx_data", txd, mrd);
      chk(rdata == m_read(sel), "R11 rdata", rdata, m_read(sel));
      beat = e_req && gnt;
      old = m_state;
      wpb = int'(m_bsz[11:2]);
      set_tc = 0; set_dma = 0;
      if (beat) begin
        bit blkend, last;
        m_addr = m_addr + 4;
        m_w++;
        blkend = (m_w == wpb);
        last = !m_mode[5] || (m_mode[1] && m_cnt == 16'd1);
        if (blkend) begin
          m_w = 0;
          if (m_mode[1] && m_cnt != 0) m_cnt--;
        end
        if (blkend && last) begin
          m_state = 0; set_tc = 1;
        end else if ((m_addr % (32'd1 << (BASE + int'(m_bsz[14:12])))) == 0) begin
          m_state = 2; set_dma = 1;
        end
      end
      if (we) begin
        case (sel)
          3'd0: if (old != 1) begin m_addr = wdata; if (old == 2) m_state = 1; end
          3'd1: if (old == 0) m_bsz = wdata[14:0];
          3'd2: if (old == 0) m_cnt = wdata[15:0];
          3'd3: if (old == 0) begin
            m_mode = wdata[5:0] & 6'b110111;
            if (wdata[0] && m_hctl[4:3] == 2'b00 && wpb != 0 &&
                !(wdata[5] && wdata[1] && m_cnt == 0)) begin
              m_state = 1; m_w = 0;
            end
          end
          3'd4: begin
            if (wdata[1] && !set_tc) m_tc = 0;
            if (wdata[3] && !set_dma) m_dma = 0;
          end
          3'd5: if (old == 0) m_hctl = wdata[7:0];
          default: ;
        endcase
      end
      if (set_tc) m_tc = 1;
      if (set_dma) m_dma = 1;
    end
  end

  task automatic wr(input logic [2:0] s, input logic [31:0] v);
    @(negedge clk);
    we = 1'b1; sel = s; wdata = v;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, input logic [31:0] exp, input string tag);
    @(negedge clk);
    sel = s;
    #2;
    chk(rdata == exp, tag, rdata, exp);
  endtask

  task automatic wait_state(input int target);
    int n = 0;
    while (m_state != target && n < 5000) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int s = 0; s < 6; s++) rd(3'(s), 32'd0, "R1 reset value");
    chk(req == 1'b0, "R1 idle no request", {31'd0, req}, 32'd0);

    // R11 readback masking
    wr(3'd1, 32'hFFFF_FFFF); rd(3'd1, 32'h7FFF, "R11 block size width");
    wr(3'd3, 32'h3E);        rd(3'd3, 32'h36, "R11 mode bits");
    wr(3'd5, 32'hAB);        rd(3'd5, 32'hAB, "R11 host control");
    wr(3'd2, 32'h12345);     rd(3'd2, 32'h2345, "R11 count width");

    // R2 start qualifiers
    wr(3'd5, 32'h10); wr(3'd1, (7 << 12) | 32); wr(3'd3, 32'h01);
    repeat (5) @(negedge clk);
    chk(req == 1'b0, "R2 no start with DMA select 10", {31'd0, req}, 32'd0);
    wr(3'd5, 32'h00); wr(3'd1, 32'd2); wr(3'd3, 32'h01);
    repeat (5) @(negedge clk);
    chk(req == 1'b0, "R2 no start with sub-word block", {31'd0, req}, 32'd0);
    wr(3'd1, 32'd32); wr(3'd2, 32'd0); wr(3'd3, 32'h23);
    repeat (5) @(negedge clk);
    chk(req == 1'b0, "R2 no start with zero count", {31'd0, req}, 32'd0);
    rd(3'd4, 32'h0, "R2 status untouched");

    // single block write to card
    wr(3'd0, 32'h100); wr(3'd1, (7 << 12) | 32); wr(3'd3, 32'h01);
    wait_state(0);
    rd(3'd0, 32'h120, "R3 address after 8 words");
    rd(3'd4, 32'h2, "R8 transfer complete");
    wr(3'd4, 32'h8); rd(3'd4, 32'h2, "R9 zero bits untouched");
    wr(3'd4, 32'h2); rd(3'd4, 32'h0, "R9 complete cleared");

    // multi block read from card with boundary pause
    wr(3'd0, 32'h1F0); wr(3'd1, 32'd16); wr(3'd2, 32'd5); wr(3'd3, 32'h33);
    wait_state(2);
    rd(3'd4, 32'h8, "R5 DMA status at boundary");
    rd(3'd0, 32'h200, "R5 paused at boundary address");
    rd(3'd2, 32'h4, "R7 count after one block");
    wr(3'd2, 32'd9); rd(3'd2, 32'h4, "R10 count write ignored when paused");
    wr(3'd3, 32'h00); rd(3'd3, 32'h33, "R10 mode write ignored when paused");
    repeat (5) @(negedge clk);
    chk(req == 1'b0, "R5 no request while paused", {31'd0, req}, 32'd0);
    wr(3'd4, 32'h8);
    wr(3'd0, 32'h200);
    wr(3'd0, 32'h5000);
    wait_state(0);
    rd(3'd0, 32'h240, "R6 R10 resumed to end address");
    rd(3'd2, 32'h0, "R7 count reaches zero");
    rd(3'd4, 32'h2, "R8 final beat on boundary sets only complete");

    // multi block without count enable runs past blocks
    wr(3'd4, 32'h2);
    wr(3'd0, 32'h0); wr(3'd1, 32'd8); wr(3'd3, 32'h21);
    wait_state(2);
    rd(3'd0, 32'h40, "R7 endless mode crosses blocks");
    rd(3'd4, 32'h8, "R5 endless mode pauses");

    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    rd(3'd4, 32'h0, "R1 status after reset");
    rd(3'd0, 32'h0, "R1 address after reset");
    repeat (3) @(negedge clk);
    chk(req == 1'b0, "R1 idle after reset", {31'd0, req}, 32'd0);
    done = 1;
    summary();
  end
endmodule